// File: doc/BRIEF.md
# Bus Release Controller

This block decides when an 8-bit processor hands its external bus to another master. A request line from that master is examined only on the CPU clock edge that closes a machine cycle. When the request is seen there, a registered acknowledge rises and the run-enable that gates the processor sequencer drops on the same master clock edge. The processor then stays frozen, with time passing but no instruction executing, until the request goes away.

The CPU clock is not a separate clock. It is a one-cycle enable pulse, `cpu_tick_o`, made by dividing the master clock by `CLK_DIV`. The processor sequencer reports the last T-state of each machine cycle on `mcycle_end_i`. The block samples that indicator together with the request only when the tick pulse is high.

There is a separate processor reset input, `cpu_reset_i`, distinct from the flop reset. It holds the block in a frozen state with both outputs low. If the request is still held when this reset is released, the bus is granted at the next CPU clock edge and no instruction runs first. When the request is withdrawn, the acknowledge clears at once. Execution restarts only at the next CPU clock edge.

Top module: `bus_release_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it, `bus_ack_o` and `run_en_o` are 0.
- R2: `cpu_tick_o` is high for exactly one master cycle in every `CLK_DIV` cycles. The first pulse comes `CLK_DIV-1` cycles after reset.
- R3: On each edge where `cpu_reset_i` is high, both outputs are cleared on that edge, and they stay 0 while it is held.
- R4: After `cpu_reset_i` falls with no request pending, or after a request is withdrawn, `run_en_o` rises on the edge that follows a master cycle in which `cpu_tick_o` is high.
- R5: If `cpu_reset_i` falls while `bus_req_i` is high, `bus_ack_o` rises at the next CPU clock edge and `run_en_o` never goes high in between.
- R6: While running, the request is taken only on an edge where `cpu_tick_o`, `mcycle_end_i` and `bus_req_i` are all high. On that edge `bus_ack_o` rises and `run_en_o` falls. Both outputs are never high together.
- R7: If the sequencer ends a machine cycle at least every 6 CPU clocks, then a request held while running is acknowledged within 6·`CLK_DIV`+2 master cycles.
- R8: When `bus_req_i` is low on an edge, `bus_ack_o` is low after that edge. `run_en_o` stays low until the next CPU clock edge.
- R9: If the request returns before execution has resumed, the acknowledge comes back at the next CPU clock edge and `run_en_o` stays low the whole time.
- R10: `mcycle_end_i` and `bus_req_i` have no effect in cycles where `cpu_tick_o` is low. `bus_ack_o` never rises on the edge after such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low flop reset |
| cpu_reset_i | input | 1 | Processor reset; freezes execution while high |
| bus_req_i | input | 1 | Bus request from the other master |
| mcycle_end_i | input | 1 | Last T-state of the current machine cycle |
| cpu_tick_o | output | 1 | CPU clock enable, one master cycle in `CLK_DIV` |
| bus_ack_o | output | 1 | Registered bus acknowledge |
| run_en_o | output | 1 | Processor sequencer enable |

## Verification
The request line is toggled at random master cycles. It is held for spans both shorter and longer than a machine cycle, so a grant taken early (off a tick or off a boundary) can be told apart from a correct one. The machine-cycle indicator is driven with random noise between ticks and with varying machine-cycle lengths of 3 to 6 CPU clocks. The noise shows whether only tick-aligned samples count, and the varying lengths exercise the latency bound. Directed cases cover reset release with the request held, a request withdrawn and re-raised within a CPU clock, and reset applied while the bus is granted. These tell the frozen, granted and resuming states apart.

// File: rtl/bus_release_pkg.sv
package bus_release_pkg;

    typedef enum logic [1:0] {
        PH_HOLD   = 2'd0,
        PH_RUN    = 2'd1,
        PH_GRANT  = 2'd2,
        PH_RESUME = 2'd3
    } phase_t;

    typedef struct packed {
        phase_t phase;
        logic   ack;
        logic   run;
    } arb_state_t;

endpackage

// File: rtl/bus_release_tick.sv
module bus_release_tick #(
    parameter int CLK_DIV = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/bus_release_fsm.sv
module bus_release_fsm
    import bus_release_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic cpu_reset_i,
    input  logic bus_req_i,
    input  logic mcycle_end_i,
    output logic ack_o,
    output logic run_o
);
    arb_state_t st_d, st_q;
    phase_t     nxt;

    always_comb begin
        nxt = st_q.phase;
        if (cpu_reset_i) begin
            nxt = PH_HOLD;
        end else begin
            unique case (st_q.phase)
                PH_HOLD: begin
                    // leaving reset: grant directly if request already held
                    if (tick_i) nxt = bus_req_i ? PH_GRANT : PH_RUN;
                end
                PH_RUN: begin
                    // sample only at a machine-cycle boundary
                    if (tick_i && mcycle_end_i && bus_req_i) nxt = PH_GRANT;
                end
                PH_GRANT: begin
                    if (!bus_req_i) nxt = PH_RESUME;
                end
                PH_RESUME: begin
                    // nothing has executed yet, so a new request re-grants
                    if (tick_i) nxt = bus_req_i ? PH_GRANT : PH_RUN;
                end
                default: nxt = PH_HOLD;
            endcase
        end
        st_d.phase = nxt;
        st_d.ack   = (nxt == PH_GRANT);
        st_d.run   = (nxt == PH_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_HOLD, ack: 1'b0, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o = st_q.ack;
    assign run_o = st_q.run;
endmodule

// File: rtl/bus_release_ctrl.sv
module bus_release_ctrl #(
    parameter int CLK_DIV = 15
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cpu_reset_i,
    input  logic bus_req_i,
    input  logic mcycle_end_i,
    output logic cpu_tick_o,
    output logic bus_ack_o,
    output logic run_en_o
);
    logic tick;

    bus_release_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    bus_release_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .tick_i       (tick),
        .cpu_reset_i  (cpu_reset_i),
        .bus_req_i    (bus_req_i),
        .mcycle_end_i (mcycle_end_i),
        .ack_o        (bus_ack_o),
        .run_o        (run_en_o)
    );

    assign cpu_tick_o = tick;
endmodule

// File: rtl/bus_release_ctrl_chk.sv
module bus_release_ctrl_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic cpu_reset_i,
    input logic bus_req_i,
    input logic mcycle_end_i,
    input logic cpu_tick_o,
    input logic bus_ack_o,
    input logic run_en_o
);
    AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_tick_o |=> !cpu_tick_o); // R2
    AST_RESET_FREEZES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cpu_reset_i |=> (!bus_ack_o && !run_en_o)); // R3
    AST_RUN_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_en_o) |-> $past(cpu_tick_o)); // R4
    AST_ACK_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bus_ack_o) |-> ($past(cpu_tick_o) && $past(bus_req_i))); // R10
    AST_ACK_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(bus_ack_o) && $past(run_en_o)) |-> $past(mcycle_end_i)); // R6
    AST_ACK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_ack_o && run_en_o)); // R6
    AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_req_i |=> !bus_ack_o); // R8
    AST_NO_RUN_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_ack_o && !cpu_tick_o) |=> !run_en_o); // R8
endmodule

bind bus_release_ctrl bus_release_ctrl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_reset_i  (cpu_reset_i),
    .bus_req_i    (bus_req_i),
    .mcycle_end_i (mcycle_end_i),
    .cpu_tick_o   (cpu_tick_o),
    .bus_ack_o    (bus_ack_o),
    .run_en_o     (run_en_o)
);

// File: tb/bus_release_ctrl_test.sv
module bus_release_ctrl_test;
    localparam int DIV = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_reset = 1'b1;
    logic bus_req = 1'b0;
    logic mcycle_end = 1'b0;
    logic cpu_tick, bus_ack, run_en;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    bus_release_ctrl #(.CLK_DIV(DIV)) uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cpu_reset_i  (cpu_reset),
        .bus_req_i    (bus_req),
        .mcycle_end_i (mcycle_end),
        .cpu_tick_o   (cpu_tick),
        .bus_ack_o    (bus_ack),
        .run_en_o     (run_en)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic  ack;
        logic  run;
        logic  tick;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // reference model (0 frozen, 1 running, 2 granted, 3 resuming)
    int m_div = 0;
    int m_st = 0;
    always @(posedge clk) begin
        exp_t e;
        bit tk;
        if (!rst_n) begin
            m_div = 0;
            m_st = 0;
        end else begin
            tk = (m_div == DIV - 1);
            m_div = tk ? 0 : m_div + 1;
            if (cpu_reset) m_st = 0;
            else case (m_st)
                0: if (tk) m_st = bus_req ? 2 : 1;
                1: if (tk && mcycle_end && bus_req) m_st = 2;
                2: if (!bus_req) m_st = 3;
                default: if (tk) m_st = bus_req ? 2 : 1;
            endcase
        end
        e.ack = (m_st == 2);
        e.run = (m_st == 1);
        e.tick = (m_div == DIV - 1);
        e.tag = (m_st == 0) ? "R3" : (m_st == 1) ? "R4" : (m_st == 2) ? "R6" : "R8";
        exp_q.push_back(e);
    end

    // monitor: scoreboard pop plus boundary and latency watches
    logic prev_tick = 1'b0;
    logic prev_ack = 1'b0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        exp_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(bus_ack === e.ack, e.tag, int'(bus_ack), int'(e.ack));
            check(run_en === e.run, e.tag, int'(run_en), int'(e.run));
            check(cpu_tick === e.tick, "R2", int'(cpu_tick), int'(e.tick));
        end
        if (rst_n && bus_ack && !prev_ack) begin
            check(prev_tick, "R10 ack rose without a tick", 0, 1);
            check(wait_cnt <= 6 * DIV + 2, "R7 latency", wait_cnt, 6 * DIV + 2);
        end
        if (run_en && bus_req) wait_cnt++;
        else wait_cnt = 0;
        prev_tick = cpu_tick;
        prev_ack = bus_ack;
    end

    // CPU sequencer stand-in: machine cycles of 3..6 CPU clocks, noise between ticks
    int seq_t = 0;
    int seq_len = 4;
    always @(posedge clk) begin
        #1;
        if (m_div == DIV - 1) begin
            mcycle_end = (seq_t == seq_len - 1);
            if (run_en) begin
                if (seq_t == seq_len - 1) begin
                    seq_t = 0;
                    seq_len = 3 + int'($urandom % 4);
                end else begin
                    seq_t++;
                end
            end
        end else begin
            mcycle_end = 1'($urandom % 2);
        end
    end

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        bit ran;
        int hold;
        cyc(5);
        @(negedge clk);
        check(bus_ack == 1'b0 && run_en == 1'b0, "R1 in reset", int'(bus_ack | run_en), 0);
        rst_n = 1'b1;
        cyc(1);
        @(negedge clk);
        check(bus_ack == 1'b0 && run_en == 1'b0, "R1 after reset", int'(bus_ack | run_en), 0);

        // R3: frozen with request toggling
        cyc(3);
        bus_req = 1'b1;
        cyc(40);
        bus_req = 1'b0;
        cyc(10);

        // R5: release reset with the request held
        bus_req = 1'b1;
        cyc(2);
        cpu_reset = 1'b0;
        ran = 1'b0;
        hold = 0;
        while (!bus_ack && hold < 3 * DIV) begin
            cyc(1);
            if (run_en) ran = 1'b1;
            hold++;
        end
        check(bus_ack && !ran, "R5 grant out of reset", int'(ran), 0);

        // R9: withdraw and re-raise before resuming
        bus_req = 1'b0;
        cyc(2);
        bus_req = 1'b1;
        ran = 1'b0;
        hold = 0;
        while (!bus_ack && hold < 3 * DIV) begin
            cyc(1);
            if (run_en) ran = 1'b1;
            hold++;
        end
        check(bus_ack && !ran, "R9 re-grant", int'(ran), 0);

        // R4: release and observe resume
        bus_req = 1'b0;
        hold = 0;
        while (!run_en && hold < 3 * DIV) begin
            cyc(1);
            hold++;
        end
        check(run_en == 1'b1, "R4 resume", int'(run_en), 1);

        // R6/R7/R10: random request activity
        for (int k = 0; k < 120; k++) begin
            bus_req = ~bus_req;
            cyc(1 + int'($urandom % 150));
        end

        // R3: reset while granted
        bus_req = 1'b1;
        hold = 0;
        while (!bus_ack && hold < 8 * DIV) begin
            cyc(1);
            hold++;
        end
        cpu_reset = 1'b1;
        cyc(1);
        @(negedge clk);
        check(bus_ack == 1'b0 && run_en == 1'b0, "R3 reset drops grant", int'(bus_ack), 0);
        bus_req = 1'b0;
        cyc(5);
        cpu_reset = 1'b0;
        cyc(3 * DIV);
        check(run_en == 1'b1, "R4 run after reset", int'(run_en), 1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule